// File: doc/BRIEF.md
# Packet-Gated Stream FIFO

This block is a single-clock first-in first-out buffer with a streaming write port and a streaming read port. Both ports use a valid/ready handshake. Each beat carries data, a byte-keep field, a byte-strobe field and an end-of-packet marker. The keep and strobe fields are stored next to the data and come out unchanged. The block does not interpret them.

In packet mode, the read port offers nothing until at least one whole packet is stored. A packet is whole once its end-of-packet beat has been written. A counter of whole stored packets sets the read valid, not mere non-emptiness. In streaming mode, which a parameter selects, the read port offers data as soon as a beat has passed through the internal pipeline.

The block has three status outputs. The write-side level counts every beat accepted and not yet read. The read-side level counts the beats the reader can already reach. A programmable-full flag compares the write-side level with a threshold parameter. Reset is synchronous and active high, and it is normally held for several clocks.

Top module: `stream_pkt_fifo`

## Requirements
- R1: While and after reset, inReady is 1, outValid is 0, wrLevel and rdLevel are 0, and progFull is 0.
- R2: A write beat is accepted on a clock edge where inValid and inReady are both 1. On that same edge wrLevel rises by one if no read is accepted on it, so back-to-back writes raise it every cycle. wrLevel is $clog2(DEPTH)+1 bits wide.
- R3: inReady is 0 while wrLevel equals DEPTH. A beat offered in that state is not stored: wrLevel stays the same and the beat never appears on the read port.
- R4: progFull is 1 exactly when wrLevel is at least PF_LEVEL. It changes on the same edge as wrLevel, so with PF_LEVEL=625 it rises on the edge that accepts the 625th beat.
- R5: In packet mode (PKT_MODE=1), outValid stays 0 until a beat with inLast=1 has been accepted.
- R6: In packet mode, the stored-packet count rises when an inLast beat is written and falls when an outLast beat is read. When both happen on the same edge, the count stays the same. outValid is 0 whenever the count is zero.
- R7: In streaming mode (PKT_MODE=0), outValid rises on the second clock edge after the edge that accepts the first beat into an empty FIFO.
- R8: rdLevel rises one edge after each accepted write and falls on each accepted read. It never rises without an earlier write, and it never exceeds wrLevel.
- R9: Beats leave in the order they were written. Data, keep, strobe and last are unchanged. While outValid is 1 and outReady is 0, the head beat holds steady.
- R10: Reset clears the stored-packet count and all stored beats. After reset, a packet left incomplete before the reset does not raise outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inData | input | DATA_W | Write beat data |
| inKeep | input | KEEP_W | Write beat byte-keep sideband |
| inStrb | input | KEEP_W | Write beat byte-strobe sideband |
| inLast | input | 1 | Write beat ends a packet |
| inValid | input | 1 | Write beat offered |
| inReady | output | 1 | FIFO can take a beat |
| outData | output | DATA_W | Head beat data |
| outKeep | output | KEEP_W | Head beat byte-keep sideband |
| outStrb | output | KEEP_W | Head beat byte-strobe sideband |
| outLast | output | 1 | Head beat ends a packet |
| outValid | output | 1 | Head beat offered to reader |
| outReady | input | 1 | Reader takes the head beat |
| wrLevel | output | CNT_W | Beats accepted and not yet read |
| rdLevel | output | CNT_W | Beats visible to the reader |
| progFull | output | 1 | wrLevel at or above PF_LEVEL |

## Verification
The packet counter can stall at zero. It can also be left nonzero by a reset, or drift when an end-of-packet write and read land on the same edge. Each of these faults shows at the read port within a few clocks. A finished packet then never drains, or outValid rises for a fragment that has no end marker. A level register that steps only every other cycle, or that misses a read, shows on wrLevel or rdLevel on the very next edge. It also moves the progFull edge away from the beat that reaches the threshold. A fault in the two-stage visibility pipeline shifts the first outValid edge of streaming mode by one clock, or corrupts the order of the beats being drained.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Strobes sent by the control to the datapath
  typedef struct packed {
    logic wrFire;   // store the input beat at the write pointer
    logic loadOut;  // move the entry at the read pointer into the head register
  } fifoStrobes_t;

endpackage

// File: rtl/sfifo_datapath.sv
module sfifo_datapath
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int KEEP_W = 1,
  parameter int DEPTH  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] inData,
  input  logic [KEEP_W-1:0] inKeep,
  input  logic [KEEP_W-1:0] inStrb,
  input  logic              inLast,
  output logic [DATA_W-1:0] outData,
  output logic [KEEP_W-1:0] outKeep,
  output logic [KEEP_W-1:0] outStrb,
  output logic              outLast
);

  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WORD_W = DATA_W + 2 * KEEP_W + 1;

  logic [WORD_W-1:0] storage [DEPTH];
  logic [PTR_W-1:0]  wrPtrQ;
  logic [PTR_W-1:0]  rdPtrQ;
  logic [WORD_W-1:0] headQ;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
    end else begin
      if (strobes.wrFire)  wrPtrQ <= bumpPtr(wrPtrQ);
      if (strobes.loadOut) rdPtrQ <= bumpPtr(rdPtrQ);
    end
  end

  // Storage has no reset; the control never reads an entry before it is written.
  always_ff @(posedge clk) begin
    if (strobes.wrFire) storage[wrPtrQ] <= {inLast, inStrb, inKeep, inData};
  end

  always_ff @(posedge clk) begin
    if (rst)                  headQ <= '0;
    else if (strobes.loadOut) headQ <= storage[rdPtrQ];
  end

  assign outData = headQ[DATA_W-1:0];
  assign outKeep = headQ[DATA_W +: KEEP_W];
  assign outStrb = headQ[DATA_W+KEEP_W +: KEEP_W];
  assign outLast = headQ[WORD_W-1];

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH    = 4096,
  parameter int PF_LEVEL = 625,
  parameter int PKT_MODE = 1,
  parameter int CNT_W    = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             outReady,
  input  logic             headLast,
  output fifoStrobes_t     strobes,
  output logic             inReady,
  output logic             outValid,
  output logic [CNT_W-1:0] wrLevel,
  output logic [CNT_W-1:0] rdLevel,
  output logic             progFull
);

  logic [CNT_W-1:0] wrLevelQ, rdLevelQ, memVisQ, wrLevelNxt;
  logic             wrFire, rdFire, loadOut, wrFireQ, headValidQ, progFullQ;
  logic             pktGate;

  assign inReady  = (wrLevelQ != CNT_W'(DEPTH));
  assign wrFire   = inValid && inReady;
  assign outValid = headValidQ && pktGate;
  assign rdFire   = outValid && outReady;
  // Refill the head register when it is empty or is being taken on this edge
  assign loadOut  = (memVisQ != '0) && (!headValidQ || rdFire);

  assign wrLevelNxt = wrLevelQ + CNT_W'(wrFire) - CNT_W'(rdFire);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrLevelQ   <= '0;
      rdLevelQ   <= '0;
      memVisQ    <= '0;
      wrFireQ    <= 1'b0;
      headValidQ <= 1'b0;
      progFullQ  <= 1'b0;
    end else begin
      wrLevelQ  <= wrLevelNxt;
      progFullQ <= (wrLevelNxt >= CNT_W'(PF_LEVEL));
      // A written beat becomes visible one edge later
      wrFireQ   <= wrFire;
      rdLevelQ  <= rdLevelQ + CNT_W'(wrFireQ) - CNT_W'(rdFire);
      memVisQ   <= memVisQ + CNT_W'(wrFireQ) - CNT_W'(loadOut);
      if (loadOut)     headValidQ <= 1'b1;
      else if (rdFire) headValidQ <= 1'b0;
    end
  end

  generate
    if (PKT_MODE != 0) begin : g_packet
      logic [CNT_W-1:0] pktCountQ;
      logic             pktInc, pktDec;
      assign pktInc = wrFire && inLast;
      assign pktDec = rdFire && headLast;
      always_ff @(posedge clk) begin
        if (rst) pktCountQ <= '0;
        else begin
          case ({pktInc, pktDec})
            2'b10:   pktCountQ <= pktCountQ + 1'b1;
            2'b01:   pktCountQ <= pktCountQ - 1'b1;
            default: pktCountQ <= pktCountQ;
          endcase
        end
      end
      assign pktGate = (pktCountQ != '0);
    end else begin : g_stream
      assign pktGate = 1'b1;
    end
  endgenerate

  assign strobes.wrFire  = wrFire;
  assign strobes.loadOut = loadOut;
  assign wrLevel  = wrLevelQ;
  assign rdLevel  = rdLevelQ;
  assign progFull = progFullQ;

endmodule

// File: rtl/stream_pkt_fifo.sv
module stream_pkt_fifo
  import sfifo_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 4096,
  parameter int PF_LEVEL = 625,
  parameter int PKT_MODE = 1,
  localparam int KEEP_W  = (DATA_W + 7) / 8,
  localparam int CNT_W   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic [KEEP_W-1:0] inKeep,
  input  logic [KEEP_W-1:0] inStrb,
  input  logic              inLast,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic [KEEP_W-1:0] outKeep,
  output logic [KEEP_W-1:0] outStrb,
  output logic              outLast,
  output logic              outValid,
  input  logic              outReady,
  output logic [CNT_W-1:0]  wrLevel,
  output logic [CNT_W-1:0]  rdLevel,
  output logic              progFull
);

  fifoStrobes_t strobes;

  sfifo_ctrl #(
    .DEPTH(DEPTH), .PF_LEVEL(PF_LEVEL), .PKT_MODE(PKT_MODE), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .outReady(outReady), .headLast(outLast), .strobes(strobes),
    .inReady(inReady), .outValid(outValid), .wrLevel(wrLevel),
    .rdLevel(rdLevel), .progFull(progFull)
  );

  sfifo_datapath #(
    .DATA_W(DATA_W), .KEEP_W(KEEP_W), .DEPTH(DEPTH)
  ) u_data (
    .clk(clk), .rst(rst), .strobes(strobes), .inData(inData),
    .inKeep(inKeep), .inStrb(inStrb), .inLast(inLast),
    .outData(outData), .outKeep(outKeep), .outStrb(outStrb), .outLast(outLast)
  );

endmodule

// File: rtl/stream_pkt_fifo_chk.sv
module stream_pkt_fifo_chk #(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 4096,
  parameter int PF_LEVEL = 625,
  parameter int PKT_MODE = 1,
  parameter int CNT_W    = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              inLast,
  input logic              outValid,
  input logic              outReady,
  input logic              outLast,
  input logic [DATA_W-1:0] outData,
  input logic [CNT_W-1:0]  wrLevel,
  input logic [CNT_W-1:0]  rdLevel,
  input logic              progFull
);

  // Independent count of whole packets inside the FIFO
  logic [CNT_W-1:0] shadowPkts;
  always_ff @(posedge clk) begin
    if (rst) shadowPkts <= '0;
    else shadowPkts <= shadowPkts + CNT_W'(inValid && inReady && inLast)
                                  - CNT_W'(outValid && outReady && outLast);
  end

  p_wr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && !(outValid && outReady)) |=> (wrLevel == $past(wrLevel) + 1'b1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    wrLevel <= CNT_W'(DEPTH));

  p_prog_full_r4: assert property (@(posedge clk) disable iff (rst)
    progFull == (wrLevel >= CNT_W'(PF_LEVEL)));

  p_pkt_gate_r5: assert property (@(posedge clk) disable iff (rst)
    ((PKT_MODE != 0) && (shadowPkts == '0)) |-> !outValid);

  p_rd_bound_r8: assert property (@(posedge clk) disable iff (rst)
    rdLevel <= wrLevel);

  p_head_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

endmodule

bind stream_pkt_fifo stream_pkt_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .PF_LEVEL(PF_LEVEL), .PKT_MODE(PKT_MODE), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inLast(inLast),
  .outValid(outValid), .outReady(outReady), .outLast(outLast), .outData(outData),
  .wrLevel(wrLevel), .rdLevel(rdLevel), .progFull(progFull)
);

// File: tb/stream_pkt_fifo_bench.sv
module stream_pkt_fifo_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  // Common stimulus, routed to one instance by sel (0: packet mode, 1: streaming)
  logic       sel = 1'b0;
  logic [7:0] inData = '0;
  logic       inLast = 1'b0, inValid = 1'b0, outReady = 1'b0;

  logic        aReady, aValid, aLast, aPf, aKeep, aStrb;
  logic [7:0]  aData;
  logic [12:0] aWr, aRd;
  logic        pReady, pValid, pLast, pPf, pKeep, pStrb;
  logic [7:0]  pData;
  logic [4:0]  pWr, pRd;

  stream_pkt_fifo u_stream_pkt_fifo (
    .clk(clk), .rst(rst), .inData(inData), .inKeep(inData[0]), .inStrb(inData[1]),
    .inLast(inLast), .inValid(inValid && !sel), .inReady(aReady),
    .outData(aData), .outKeep(aKeep), .outStrb(aStrb), .outLast(aLast),
    .outValid(aValid), .outReady(outReady && !sel),
    .wrLevel(aWr), .rdLevel(aRd), .progFull(aPf));

  stream_pkt_fifo #(.DEPTH(16), .PF_LEVEL(10), .PKT_MODE(0)) u_stream_plain (
    .clk(clk), .rst(rst), .inData(inData), .inKeep(inData[0]), .inStrb(inData[1]),
    .inLast(inLast), .inValid(inValid && sel), .inReady(pReady),
    .outData(pData), .outKeep(pKeep), .outStrb(pStrb), .outLast(pLast),
    .outValid(pValid), .outReady(outReady && sel),
    .wrLevel(pWr), .rdLevel(pRd), .progFull(pPf));

  wire        oReady = sel ? pReady : aReady;
  wire        oValid = sel ? pValid : aValid;
  wire [10:0] oBeat  = sel ? {pLast, pStrb, pKeep, pData} : {aLast, aStrb, aKeep, aData};
  wire [12:0] wrL    = sel ? 13'(pWr) : aWr;
  wire [12:0] rdL    = sel ? 13'(pRd) : aRd;
  wire        pf     = sel ? pPf : aPf;

  int nChecks = 0;
  int nFail   = 0;
  logic [10:0] expQ[$];

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: record write and read fires decided by the current values, then move to the next negedge
  task automatic cyc();
    if (inValid && oReady) expQ.push_back({inLast, inData[1], inData[0], inData});
    if (oValid && outReady) begin
      if (expQ.size() == 0) check("R9 unexpected beat", int'(oBeat), -1);
      else check("R9 beat order/content", int'(oBeat), int'(expQ.pop_front()));
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; inValid = 1'b0; inLast = 1'b0; outReady = 1'b0;
    for (int i = 0; i < 10; i++) cyc();
    rst = 1'b0;
    expQ.delete();
    cyc();
  endtask

  task automatic drain(input string req);
    outReady = 1'b1; inValid = 1'b0;
    for (int i = 0; i < 5000 && expQ.size() != 0; i++) cyc();
    check(req, expQ.size(), 0);
  endtask

  task automatic t_reset_state();
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      check("R1 inReady", int'(oReady), 1);
      check("R1 outValid", int'(oValid), 0);
      check("R1 wrLevel", int'(wrL), 0);
      check("R1 rdLevel", int'(rdL), 0);
      check("R1 progFull", int'(pf), 0);
    end
    sel = 1'b0;
  endtask

  task automatic t_big_packet();
    sel = 1'b0; outReady = 1'b0;
    for (int i = 0; i < 625; i++) begin
      inValid = 1'b1; inData = 8'(i * 7 + 3); inLast = (i == 624);
      cyc();
      check("R2 wrLevel step", int'(wrL), i + 1);
      check("R8 rdLevel lag", int'(rdL), i);
      if (i < 624) check("R5 no valid before last", int'(oValid), 0);
      if (i == 623) check("R4 progFull below", int'(pf), 0);
      if (i == 624) check("R4 progFull at level", int'(pf), 1);
    end
    inValid = 1'b0; inLast = 1'b0;
    cyc();
    check("R5 valid after last", int'(oValid), 1);
    check("R8 rdLevel all visible", int'(rdL), 625);
    drain("R9 packet drained");
    check("R2 wrLevel empty", int'(wrL), 0);
    check("R4 progFull cleared", int'(pf), 0);
    outReady = 1'b0;
    for (int i = 0; i < 4; i++) cyc();
    check("R8 rdLevel idle", int'(rdL), 0);
    check("R5 idle no valid", int'(oValid), 0);
  endtask

  task automatic t_overlap();
    sel = 1'b0; outReady = 1'b0;
    for (int i = 0; i < 3; i++) begin
      inValid = 1'b1; inData = 8'(8'h40 + i); inLast = (i == 2); cyc();
    end
    inValid = 1'b0; inLast = 1'b0;
    for (int i = 0; i < 3; i++) cyc();
    // Packet A read while packet B written; last beats coincide on the third edge
    outReady = 1'b1;
    for (int i = 0; i < 3; i++) begin
      inValid = 1'b1; inData = 8'(8'h80 + i); inLast = (i == 2); cyc();
    end
    inLast = 1'b0;
    drain("R6 both packets drained");
    inValid = 1'b1; inData = 8'hC5; inLast = 1'b0; cyc();
    inValid = 1'b0;
    for (int i = 0; i < 5; i++) cyc();
    check("R6 count back to zero", int'(oValid), 0);
    check("R6 fragment held", int'(wrL), 1);
  endtask

  task automatic t_reset_clears();
    sel = 1'b0;
    doReset();
    outReady = 1'b0;
    for (int i = 0; i < 2; i++) begin
      inValid = 1'b1; inData = 8'(8'h20 + i); inLast = (i == 1); cyc();
    end
    inValid = 1'b0; inLast = 1'b0;
    for (int i = 0; i < 3; i++) cyc();
    check("R10 packet ready before reset", int'(oValid), 1);
    doReset();
    check("R10 valid cleared", int'(oValid), 0);
    check("R10 level cleared", int'(wrL), 0);
    inValid = 1'b1; inData = 8'h33; inLast = 1'b0; cyc();
    inValid = 1'b0;
    for (int i = 0; i < 5; i++) cyc();
    check("R10 fragment gated", int'(oValid), 0);
    check("R8 fragment visible count", int'(rdL), 1);
  endtask

  task automatic t_stream_latency();
    sel = 1'b1;
    doReset();
    inValid = 1'b1; inData = 8'h5A; inLast = 1'b0; cyc();
    inValid = 1'b0;
    check("R7 low after accept", int'(oValid), 0);
    check("R2 plain wrLevel", int'(wrL), 1);
    check("R8 not yet visible", int'(rdL), 0);
    cyc();
    check("R7 low one edge later", int'(oValid), 0);
    check("R8 visible one edge later", int'(rdL), 1);
    cyc();
    check("R7 high two edges later", int'(oValid), 1);
  endtask

  task automatic t_full();
    sel = 1'b1; outReady = 1'b0;
    for (int i = 1; i < 16; i++) begin
      inValid = 1'b1; inData = 8'(i); inLast = (i == 15); cyc();
      if (i == 8) check("R4 plain below", int'(pf), 0);
      if (i == 9) check("R4 plain at level", int'(pf), 1);
    end
    check("R3 level full", int'(wrL), 16);
    check("R3 ready low", int'(oReady), 0);
    inValid = 1'b1; inData = 8'hEE; inLast = 1'b1;
    for (int i = 0; i < 3; i++) cyc();
    check("R3 level unchanged", int'(wrL), 16);
    inLast = 1'b0;
    drain("R3 only stored beats drained");
    for (int i = 0; i < 3; i++) cyc();
    check("R3 rejected beat absent", int'(oValid), 0);
    check("R3 empty level", int'(wrL), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    doReset();
    t_reset_state();
    t_big_packet();
    t_overlap();
    t_reset_clears();
    t_stream_latency();
    t_full();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule